// File: doc/BRIEF.md
# Double-Buffered Timer Update Control

This block is a 16-bit timer/counter that counts up or down, with one period register and four compare/capture channels. Software never writes an active register directly. Each write goes into a buffer sitting in front of the active register, and a per-register pending flag records that the buffer holds a new value.

The pending buffers move into the active registers together, on an update strobe. The strobe fires when the count wraps. Software can also raise it with a command. A lock bit lets software stage several buffers without any of them taking effect early.

A write-only command field can force an update, restart the count, or return the whole block to its reset state. The reset command works only while the timer is stopped. Any channel can be switched to capture mode. In that mode the channel stores the count when its event input pulses. Its pending flag then means "a capture is waiting" and is cleared by acknowledging the channel's capture flag.

Software reaches the block through a single-cycle write port and a read port with one cycle of latency. The direction and lock bits, and the pending flags, each have a set address and a clear address.

Top module: `tc_update_ctrl`

## Requirements
- R1: A write to the control-set address (2) carries a command in wr_data[3:2]: 0 none, 1 force update, 2 restart, 3 hard reset. The command is not stored. Bits 3:2 read back as 0 at both control addresses.
- R2: The direction bit (bit 0) and the lock bit (bit 1) are set by writing 1s to address 2 and cleared by writing 1s to address 1. Both addresses read back the current value {lock, dir}.
- R3: Writing the period buffer (address 8) or channel buffer i (address 9+i) sets that register's pending flag. In the status word, read at address 3 or 4, bit 0 is the period flag, bits 4:1 are the flags of channels 0..3, and all higher bits read 0.
- R4: On an update strobe, each register whose pending flag is set and whose channel is in compare mode copies its buffer into its active register, and its flag clears. The active period reads at address 7, the period buffer at address 8, and active channel i at address 9+i.
- R5: While the lock bit is set, an update strobe transfers nothing and leaves every pending flag set.
- R6: The configuration word (address 0) is {capture enables for channels 3..0 in bits 4:1, run in bit 0}. While run is 1, the count (address 6) steps once per cycle. With dir 0 it counts up and goes from the period value to 0. With dir 1 it counts down and goes from 0 to the period value.
- R7: A natural update strobe fires in the cycle the running count sits at the period value while counting up, or at 0 while counting down.
- R8: A restart command sets the count to 0 and the direction to up. Buffers, pending flags and active registers are left as they are.
- R9: A hard-reset command while run is 1 is ignored. While run is 0 it clears the count, direction, lock, buffers, pending flags and capture flags, sets the active period to all ones, and clears the active channels. The configuration word is kept.
- R10: A channel in capture mode stores the current count into its active register when its cap_ev bit is 1. This also sets its pending flag and its capture flag. The lock bit does not hold back a capture, and buffer writes and update strobes leave a capture channel unchanged.
- R11: Writing 1s to address 5 clears those capture flags, which read at address 5 and drive cap_flag. Clearing a capture-mode channel's flag also clears its pending flag.
- R12: Writing 1s to address 4 sets pending flags, and writing 1s to address 3 clears them. A buffer write to a register wins over a clear of that register's flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, one cycle after rd_addr |
| cap_ev | input | 4 | Capture event per channel |
| cap_flag | output | 4 | Capture flag per channel |

## Verification
The assertions check four things on every cycle:
- the command field and the reserved status bits always read back as 0;
- an update strobe while locked never moves the active period;
- an unlocked strobe always clears a pending period flag that was not rewritten in the same cycle;
- a hard-reset command while running never drops the lock bit, and a capture event always leaves the channel pending.

Only the bench scenarios can show the rest. That covers the count values reached by up and down sweeps, and the exact cycle in which a natural wrap moves a staged period. It also covers that a capture ignores the lock, and that restart keeps staged buffers while hard reset clears everything except the configuration.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_UPDATE  = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_HRESET  = 2'd3
  } tc_cmd_e;

  localparam logic [AW-1:0] A_CFG      = 4'd0;
  localparam logic [AW-1:0] A_CTRL_CLR = 4'd1;
  localparam logic [AW-1:0] A_CTRL_SET = 4'd2;
  localparam logic [AW-1:0] A_STAT_CLR = 4'd3;
  localparam logic [AW-1:0] A_STAT_SET = 4'd4;
  localparam logic [AW-1:0] A_CAPF     = 4'd5;
  localparam logic [AW-1:0] A_COUNT    = 4'd6;
  localparam logic [AW-1:0] A_PER      = 4'd7;
  localparam logic [AW-1:0] A_PER_BUF  = 4'd8;
  localparam logic [AW-1:0] A_CC0      = 4'd9;
endpackage

// File: rtl/tc_buf_reg.sv
// One staged register: a buffer, an active copy and a pending flag.
module tc_buf_reg #(
  parameter int unsigned W       = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit          CAP     = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hrst,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         upd,
  input  logic         lock,
  input  logic         cap_mode,
  input  logic         cap_ev,
  input  logic [W-1:0] cap_val,
  input  logic         ack,
  input  logic         sw_set,
  input  logic         sw_clr,
  output logic [W-1:0] act_o,
  output logic [W-1:0] buf_o,
  output logic         pend_o
);
  logic         cap_m;
  logic         xfer;
  logic [W-1:0] buf_q, act_q;
  logic         pend_q;

  assign cap_m = CAP ? cap_mode : 1'b0;
  assign xfer  = upd && pend_q && !lock;

  always_ff @(posedge clk) begin
    if (rst || hrst) begin
      buf_q  <= '0;
      act_q  <= RST_VAL;
      pend_q <= 1'b0;
    end else if (cap_m) begin
      if (cap_ev) act_q <= cap_val;
      if (cap_ev || sw_set)   pend_q <= 1'b1;
      else if (ack || sw_clr) pend_q <= 1'b0;
    end else begin
      if (buf_we) buf_q <= buf_wd;
      if (xfer)   act_q <= buf_q;
      if (buf_we || sw_set)    pend_q <= 1'b1;
      else if (xfer || sw_clr) pend_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign buf_o  = buf_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/tc_counter.sv
// Up/down count with wrap at the period and the natural update strobe.
module tc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hrst,
  input  logic         restart,
  input  logic         run,
  input  logic         dir,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = dir ? (cnt_q == '0) : (cnt_q == per);

  always_ff @(posedge clk) begin
    if (rst || hrst || restart) cnt_q <= '0;
    else if (run) begin
      if (!dir) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      else      cnt_q <= at_end ? per : cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run && at_end;
endmodule

// File: rtl/tc_update_ctrl.sv
module tc_update_ctrl
  import tc_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  input  logic [NCH-1:0] cap_ev,
  output logic [NCH-1:0] cap_flag
);
  localparam int unsigned NREG = NCH + 1;

  logic           run_q, dir_q, lock_q;
  logic [NCH-1:0] cap_q, capf_q, ack;
  logic           wr_set, wr_clr;
  tc_cmd_e        cmd;
  logic           force_upd, restart, hrst_go, upd, wrap;
  logic [W-1:0]   cnt;
  logic [NREG-1:0] pend, fset, fclr;
  logic [W-1:0]   per_act, per_buf;
  logic [W-1:0]   cc_act [NCH];
  logic [W-1:0]   rd_n;

  assign wr_set    = wr_en && (wr_addr == A_CTRL_SET);
  assign wr_clr    = wr_en && (wr_addr == A_CTRL_CLR);
  assign cmd       = wr_set ? tc_cmd_e'(wr_data[3:2]) : CMD_NONE;
  assign force_upd = (cmd == CMD_UPDATE);
  assign restart   = (cmd == CMD_RESTART);
  assign hrst_go   = (cmd == CMD_HRESET) && !run_q;
  assign upd       = wrap || force_upd;

  assign ack  = (wr_en && wr_addr == A_CAPF) ? wr_data[NCH-1:0] : '0;
  assign fset = (wr_en && wr_addr == A_STAT_SET) ? wr_data[NREG-1:0] : '0;
  assign fclr = (wr_en && wr_addr == A_STAT_CLR) ? wr_data[NREG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cap_q <= '0;
    end else if (wr_en && wr_addr == A_CFG) begin
      run_q <= wr_data[0];
      cap_q <= wr_data[NCH:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hrst_go) begin
      dir_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (restart)     dir_q <= 1'b0;
      else if (wr_set) dir_q <= dir_q | wr_data[0];
      else if (wr_clr) dir_q <= dir_q & ~wr_data[0];
      if (wr_set)      lock_q <= lock_q | wr_data[1];
      else if (wr_clr) lock_q <= lock_q & ~wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hrst_go) capf_q <= '0;
    else                capf_q <= (capf_q & ~ack) | (cap_ev & cap_q);
  end

  tc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .hrst(hrst_go), .restart(restart),
    .run(run_q), .dir(dir_q), .per(per_act),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  tc_buf_reg #(.W(W), .RST_VAL({W{1'b1}}), .CAP(1'b0)) u_per (
    .clk(clk), .rst(rst), .hrst(hrst_go),
    .buf_we(wr_en && wr_addr == A_PER_BUF), .buf_wd(wr_data),
    .upd(upd), .lock(lock_q),
    .cap_mode(1'b0), .cap_ev(1'b0), .cap_val(cnt), .ack(1'b0),
    .sw_set(fset[0]), .sw_clr(fclr[0]),
    .act_o(per_act), .buf_o(per_buf), .pend_o(pend[0])
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] unused_buf;
    tc_buf_reg #(.W(W), .RST_VAL('0), .CAP(1'b1)) u_cc (
      .clk(clk), .rst(rst), .hrst(hrst_go),
      .buf_we(wr_en && wr_addr == A_CC0 + AW'(i)), .buf_wd(wr_data),
      .upd(upd), .lock(lock_q),
      .cap_mode(cap_q[i]), .cap_ev(cap_ev[i]), .cap_val(cnt), .ack(ack[i]),
      .sw_set(fset[i+1]), .sw_clr(fclr[i+1]),
      .act_o(cc_act[i]), .buf_o(unused_buf), .pend_o(pend[i+1])
    );
  end

  always_comb begin
    rd_n = '0;
    case (rd_addr)
      A_CFG:                  rd_n = W'({cap_q, run_q});
      A_CTRL_CLR, A_CTRL_SET: rd_n = W'({lock_q, dir_q});
      A_STAT_CLR, A_STAT_SET: rd_n = W'(pend);
      A_CAPF:                 rd_n = W'(capf_q);
      A_COUNT:                rd_n = cnt;
      A_PER:                  rd_n = per_act;
      A_PER_BUF:              rd_n = per_buf;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (rd_addr == A_CC0 + AW'(i)) rd_n = cc_act[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  assign cap_flag = capf_q;
endmodule

// File: rtl/tc_update_ctrl_chk.sv
module tc_update_ctrl_chk
  import tc_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [W-1:0]   wr_data,
  input logic [AW-1:0]  rd_addr,
  input logic [W-1:0]   rd_data,
  input logic           lock_q,
  input logic           run_q,
  input logic           upd,
  input logic           hrst_go,
  input logic [W-1:0]   per_act,
  input logic [NCH:0]   pend,
  input logic [NCH-1:0] cap_q,
  input logic [NCH-1:0] cap_ev
);
  // R1: command field never reads back
  a_r1_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CTRL_SET || $past(rd_addr) == A_CTRL_CLR) |-> rd_data[3:2] == 2'b00);

  // R3: bits above the pending flags read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_STAT_SET || $past(rd_addr) == A_STAT_CLR) |-> rd_data[W-1:NCH+1] == '0);

  // R4: an unlocked strobe consumes a pending period not rewritten or set in the same cycle
  a_r4_update_clears_pending: assert property (@(posedge clk) disable iff (rst)
    (upd && !lock_q && pend[0] &&
     !(wr_en && (wr_addr == A_PER_BUF || wr_addr == A_STAT_SET))) |=> !pend[0]);

  // R5: locked strobe leaves the active period alone
  a_r5_lock_holds_period: assert property (@(posedge clk) disable iff (rst)
    (upd && lock_q && !hrst_go) |=> $stable(per_act));

  // R9: hard reset while running leaves the lock bit set
  a_r9_hreset_ignored_running: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL_SET && wr_data[3:2] == 2'b11 && run_q && lock_q) |=> lock_q);

  // R10: a capture event leaves the channel pending
  for (genvar i = 0; i < NCH; i++) begin : g_cap
    a_r10_capture_sets_pending: assert property (@(posedge clk) disable iff (rst)
      (cap_q[i] && cap_ev[i] && !hrst_go) |=> pend[i+1]);
  end
endmodule

bind tc_update_ctrl tc_update_ctrl_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .lock_q(lock_q), .run_q(run_q),
  .upd(upd), .hrst_go(hrst_go), .per_act(per_act), .pend(pend),
  .cap_q(cap_q), .cap_ev(cap_ev)
);

// File: tb/tc_update_ctrl_tb.sv
`timescale 1ns/1ps
module tc_update_ctrl_tb;
  localparam int W = 16;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [W-1:0]   wr_data = '0;
  logic [3:0]     rd_addr = '0;
  logic [W-1:0]   rd_data;
  logic [NCH-1:0] cap_ev = '0;
  logic [NCH-1:0] cap_flag;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tc_update_ctrl #(.W(W), .NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_ev(cap_ev), .cap_flag(cap_flag)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic run_steps(input int n, input logic [W-1:0] cfg_rest);
    wr(4'd0, cfg_rest | 16'h1);
    repeat (n) @(negedge clk);
    wr(4'd0, cfg_rest);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] em;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rchk("R9 reset count", 4'd6, 16'h0);
    rchk("R9 reset period", 4'd7, 16'hFFFF);
    rchk("R3 reset status", 4'd3, 16'h0);
    rchk("R2 reset ctrl", 4'd2, 16'h0);
    rchk("R4 reset cc0", 4'd9, 16'h0);

    // R2 set/clear
    wr(4'd2, 16'h3);
    rchk("R2 set via set addr", 4'd2, 16'h3);
    rchk("R2 same via clr addr", 4'd1, 16'h3);
    wr(4'd1, 16'h2);
    rchk("R2 clear lock", 4'd2, 16'h1);
    wr(4'd1, 16'h1);
    rchk("R2 clear dir", 4'd1, 16'h0);

    // R3 pending flags accumulate
    em = '0;
    wr(4'd8, 16'd5); em |= 16'h1;
    rchk("R3 period pending", 4'd4, em);
    for (int i = 0; i < NCH; i++) begin
      wr(4'(9 + i), 16'(16'h100 * (i + 1) + i));
      em |= 16'(1 << (i + 1));
      rchk("R3 channel pending", 4'd3, em);
    end

    // R4 force update
    wr(4'd2, 16'h4);
    rchk("R1 command reads zero", 4'd2, 16'h0);
    rchk("R4 period moved", 4'd7, 16'd5);
    for (int i = 0; i < NCH; i++)
      rchk("R4 channel moved", 4'(9 + i), 16'(16'h100 * (i + 1) + i));
    rchk("R4 flags cleared", 4'd3, 16'h0);

    // R5 lock
    wr(4'd2, 16'h2);
    wr(4'd8, 16'd7);
    wr(4'd9, 16'hAA);
    wr(4'd2, 16'h4);
    rchk("R5 period held", 4'd7, 16'd5);
    rchk("R5 cc0 held", 4'd9, 16'h100);
    rchk("R5 flags kept", 4'd3, 16'h3);
    rchk("R1 lock kept, cmd zero", 4'd2, 16'h2);
    wr(4'd1, 16'h2);
    wr(4'd2, 16'h4);
    rchk("R5 period after unlock", 4'd7, 16'd7);
    rchk("R5 cc0 after unlock", 4'd9, 16'hAA);
    rchk("R5 flags after unlock", 4'd3, 16'h0);
    wr(4'd8, 16'd5);
    wr(4'd2, 16'h4);

    // R6 counting sweep, period 5
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 10; n++) begin
        int k;
        int e;
        wr(4'd2, 16'h8);
        if (d == 1) wr(4'd2, 16'h1);
        run_steps(n, 16'h0);
        k = n + 1;
        e = (d == 0) ? (k % 6) : ((6 - (k % 6)) % 6);
        rchk(d == 0 ? "R6 up count" : "R6 down count", 4'd6, 16'(e));
      end
    end

    // R7 natural update, counting up
    wr(4'd2, 16'h8);
    wr(4'd8, 16'd2);
    run_steps(3, 16'h0);
    rchk("R7 no early update count", 4'd6, 16'd4);
    rchk("R7 no early update period", 4'd7, 16'd5);
    rchk("R7 still pending", 4'd3, 16'h1);
    run_steps(1, 16'h0);
    rchk("R7 wrap count", 4'd6, 16'd0);
    rchk("R7 wrap moved period", 4'd7, 16'd2);
    rchk("R7 wrap cleared flag", 4'd3, 16'h0);

    // R7 natural update, counting down
    wr(4'd2, 16'h8);
    wr(4'd2, 16'h1);
    wr(4'd8, 16'd4);
    run_steps(0, 16'h0);
    rchk("R7 down reload count", 4'd6, 16'd2);
    rchk("R7 down moved period", 4'd7, 16'd4);

    // R8 restart
    wr(4'd8, 16'd9);
    wr(4'd2, 16'h8);
    rchk("R8 count zero", 4'd6, 16'd0);
    rchk("R8 dir up", 4'd2, 16'h0);
    rchk("R8 buffer kept", 4'd8, 16'd9);
    rchk("R8 flag kept", 4'd3, 16'h1);
    rchk("R8 period kept", 4'd7, 16'd4);
    wr(4'd2, 16'h4);

    // R10 / R11 capture on channel 1
    run_steps(2, 16'h4);
    cap_ev = 4'b0010;
    @(negedge clk);
    cap_ev = '0;
    rchk("R10 captured count", 4'd10, 16'd3);
    rchk("R10 pending set", 4'd3, 16'h4);
    rchk("R11 flag read", 4'd5, 16'h2);
    chk("R11 flag port", 16'(cap_flag), 16'h2);
    wr(4'd2, 16'h2);
    wr(4'd10, 16'h55);
    wr(4'd2, 16'h4);
    rchk("R10 write/update ignored", 4'd10, 16'd3);
    rchk("R10 pending unchanged", 4'd3, 16'h4);
    run_steps(1, 16'h4);
    cap_ev = 4'b0010;
    @(negedge clk);
    cap_ev = '0;
    rchk("R10 capture despite lock", 4'd10, 16'd5);
    wr(4'd5, 16'h2);
    rchk("R11 ack clears pending", 4'd3, 16'h0);
    rchk("R11 ack clears flag", 4'd5, 16'h0);
    wr(4'd1, 16'h2);
    wr(4'd0, 16'h0);

    // R12 software set/clear of pending flags
    wr(4'd4, 16'h1F);
    rchk("R12 set flags", 4'd3, 16'h1F);
    wr(4'd3, 16'h05);
    rchk("R12 clear flags", 4'd4, 16'h1A);

    // R9 hard reset
    wr(4'd2, 16'h2);
    wr(4'd0, 16'h1);
    wr(4'd2, 16'hC);
    wr(4'd0, 16'h0);
    rchk("R9 ignored while running", 4'd2, 16'h2);
    rchk("R9 period kept while running", 4'd7, 16'd9);
    wr(4'd0, 16'h4);
    wr(4'd2, 16'hC);
    rchk("R9 ctrl cleared", 4'd2, 16'h0);
    rchk("R9 status cleared", 4'd3, 16'h0);
    rchk("R9 period to ones", 4'd7, 16'hFFFF);
    rchk("R9 count cleared", 4'd6, 16'h0);
    rchk("R9 cc1 cleared", 4'd10, 16'h0);
    rchk("R9 config kept", 4'd0, 16'h4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule